// File: doc/BRIEF.md
# SPI slave DMA word mover

This block is the slave side of an SPI link. It moves whole words between the serial pins and a four-entry word FIFO that a DMA engine drains or fills. SCK, MOSI and the active-low slave select are brought into the system clock through two flip-flop stages. Clock polarity and phase choose which SCK edge samples MOSI and which edge moves the next bit onto MISO. Words are 8 or 16 bits long and travel MSB first.

The direction is fixed by configuration. In receive direction, each word taken from MOSI goes into the FIFO, and the block asks the DMA engine to take words while any are stored. In transmit direction, the block asks the DMA engine for words while the FIFO has room, and shifts those words out on MISO. A word counter, loaded before the transfer, limits how many words the DMA engine moves. The serial side does not depend on the counter and keeps working for as long as slave select is held. Two configuration bits decide what happens when the FIFO is full in receive direction and when it is empty in transmit direction.

Top module: `spi_dma_slave`

## Requirements
- R1: In receive direction (cfg_tx_dir_i=0), dma_req_o is high exactly when the FIFO holds at least one word and cnt_o is non-zero.
- R2: In transmit direction (cfg_tx_dir_i=1), dma_req_o is high exactly when the FIFO has a free slot and cnt_o is non-zero. tx_empty_o reads 1 exactly when the FIFO is empty.
- R3: An acknowledge taken while dma_req_o is high moves one FIFO word and lowers cnt_o by one. An acknowledge taken while dma_req_o is low changes nothing. A pulse on cnt_load_i loads cnt_o from cnt_value_i and empties the FIFO.
- R4: When cnt_o is 0, the serial side keeps shifting, and received words still update rx_buf_o, but dma_req_o stays low.
- R5: In receive direction with a full FIFO and cfg_overwrite_i=1, a new word replaces rx_buf_o and the FIFO contents stay as they were.
- R6: In receive direction with a full FIFO and cfg_overwrite_i=0, a new word is dropped, and both rx_buf_o and the FIFO stay unchanged.
- R7: In receive direction, MISO sends all zeros when cfg_zero_fill_i=1. When cfg_zero_fill_i=0, it sends the last value written through tx_wr_i/tx_wdata_i, repeated for every word.
- R8: In receive direction, tx_empty_o reads 1 and underrun_o never pulses.
- R9: In transmit direction, when a word is due and the FIFO is empty, underrun_o pulses. MISO then sends zeros if cfg_zero_fill_i=1, or repeats the last word taken from the FIFO if cfg_zero_fill_i=0.
- R10: In transmit direction, received serial data is ignored: rx_buf_o does not change and nothing is pushed into the FIFO.
- R11: Words are 16 bits when cfg_wide_i=1 and 8 bits when cfg_wide_i=0, shifted MSB first. An 8-bit word uses bits 7:0 and is zero-extended in rx_buf_o and dma_rdata_o. The leading edge is rising for cfg_cpol_i=0 and falling for cfg_cpol_i=1. cfg_cpha_i=0 samples on the leading edge and cfg_cpha_i=1 samples on the trailing edge, in every combination.
- R12: In receive direction, the DMA engine reads words on dma_rdata_o in the order they arrived. The head word is valid before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_tx_dir_i | input | 1 | 0 receive direction, 1 transmit direction |
| cfg_wide_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cfg_cpol_i | input | 1 | SCK idle level |
| cfg_cpha_i | input | 1 | 0 samples on leading edge, 1 on trailing edge |
| cfg_overwrite_i | input | 1 | Full-FIFO receive policy: 1 overwrite rx_buf_o, 0 drop |
| cfg_zero_fill_i | input | 1 | Empty-data transmit policy: 1 zeros, 0 repeat |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data out |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | One-cycle DMA acknowledge |
| dma_wdata_i | input | 16 | Word written into the FIFO in transmit direction |
| dma_rdata_o | output | 16 | FIFO head word in receive direction |
| cnt_load_i | input | 1 | Load word counter and empty FIFO |
| cnt_value_i | input | 16 | Word counter load value |
| cnt_o | output | 16 | Remaining DMA word count |
| tx_wr_i | input | 1 | Write strobe for the transmit data register |
| tx_wdata_i | input | 16 | Transmit data register value |
| rx_buf_o | output | 16 | Last received word kept |
| tx_empty_o | output | 1 | Transmit buffer empty flag |
| underrun_o | output | 1 | One-cycle pulse on transmit underrun |

## Verification
The hardest conditions to reach are the full-FIFO receive policies and the transmit run-dry repeat. Both need the serial side to get ahead of the DMA side. The stimulus holds the acknowledge off while it pushes five or six words through one slave-select burst. It then drains the FIFO and compares both the drained words and rx_buf_o against a queue model. In transmit direction, the bench fills the FIFO and then clocks out more words than were supplied. In phase-0 modes the block preloads the next word at the last trailing edge, so the expected underrun count includes that extra load.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dma_dir_e;
endpackage

// File: rtl/spi_dma_sync.sv
module spi_dma_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/spi_dma_fifo.sv
module spi_dma_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= wdata_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  // R6
  fifo_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !flush_i) |-> pop_i);
  // R3
  fifo_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !flush_i) |-> !pop_i);
  // R12
  fifo_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q) + (AW+1)'(1)));
endmodule

// File: rtl/spi_dma_shifter.sv
module spi_dma_shifter #(
  parameter int MAX_W    = 16,
  parameter int NARROW_W = 8,
  localparam int BW      = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             ss_act_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             wide_i,
  input  logic [MAX_W-1:0] load_word_i,
  output logic             load_o,
  output logic             word_done_o,
  output logic [MAX_W-1:0] rx_word_o,
  output logic             miso_o
);
  logic             sck_q, ss_q;
  logic [BW-1:0]    bit_q, last_bit;
  logic [MAX_W-1:0] tx_sr_q, rx_sr_q, rx_next, mask;
  logic             rise, fall, lead, trail, samp, shft, ss_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b0;
    end else begin
      sck_q <= sck_i;
      ss_q  <= ss_act_i;
    end
  end

  assign rise     = sck_i & ~sck_q;
  assign fall     = ~sck_i & sck_q;
  assign lead     = cpol_i ? fall : rise;
  assign trail    = cpol_i ? rise : fall;
  assign samp     = ss_act_i & (cpha_i ? trail : lead);
  assign shft     = ss_act_i & (cpha_i ? lead : trail);
  assign ss_start = ss_act_i & ~ss_q;
  assign last_bit = wide_i ? BW'(MAX_W-1) : BW'(NARROW_W-1);
  assign mask     = wide_i ? '1 : {{(MAX_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign rx_next  = {rx_sr_q[MAX_W-2:0], mosi_i};

  // phase 0 preloads at select; otherwise load at first drive edge of a word
  assign load_o = (ss_start & ~cpha_i) | (shft & (bit_q == '0));
  assign miso_o = wide_i ? tx_sr_q[MAX_W-1] : tx_sr_q[NARROW_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q     <= '0;
      rx_sr_q     <= '0;
      bit_q       <= '0;
      word_done_o <= 1'b0;
      rx_word_o   <= '0;
    end else begin
      word_done_o <= 1'b0;
      if (load_o)    tx_sr_q <= load_word_i;
      else if (shft) tx_sr_q <= tx_sr_q << 1;
      if (!ss_act_i) begin
        bit_q <= '0;
      end else if (samp) begin
        rx_sr_q <= rx_next;
        if (bit_q == last_bit) begin
          bit_q       <= '0;
          word_done_o <= 1'b1;
          rx_word_o   <= rx_next & mask;
        end else begin
          bit_q <= bit_q + BW'(1);
        end
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_o |=> !word_done_o);
endmodule

// File: rtl/spi_dma_slave.sv
module spi_dma_slave
  import spi_dma_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_tx_dir_i,
  input  logic          cfg_wide_i,
  input  logic          cfg_cpol_i,
  input  logic          cfg_cpha_i,
  input  logic          cfg_overwrite_i,
  input  logic          cfg_zero_fill_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          ss_ni,
  output logic          miso_o,
  output logic          dma_req_o,
  input  logic          dma_ack_i,
  input  logic [DW-1:0] dma_wdata_i,
  output logic [DW-1:0] dma_rdata_o,
  input  logic          cnt_load_i,
  input  logic [CW-1:0] cnt_value_i,
  output logic [CW-1:0] cnt_o,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_wdata_i,
  output logic [DW-1:0] rx_buf_o,
  output logic          tx_empty_o,
  output logic          underrun_o
);
  dma_dir_e      dir;
  logic [2:0]    pins_s;
  logic          sck_s, mosi_s, ss_act;
  logic          load, done, full, empty, push, pop, acc;
  logic [DW-1:0] rx_word, head, fifo_wdata, load_word;
  logic [DW-1:0] tdbr_q, last_q;
  logic [CW-1:0] cnt_q;

  assign dir = dma_dir_e'(cfg_tx_dir_i);

  spi_dma_sync #(.W(3)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({ss_ni, mosi_i, sck_i}),
    .q_o (pins_s)
  );
  assign sck_s  = pins_s[0];
  assign mosi_s = pins_s[1];
  assign ss_act = ~pins_s[2];

  spi_dma_shifter #(.MAX_W(DW), .NARROW_W(NW)) u_shift (
    .clk_i, .rst_ni,
    .sck_i       (sck_s),
    .mosi_i      (mosi_s),
    .ss_act_i    (ss_act),
    .cpol_i      (cfg_cpol_i),
    .cpha_i      (cfg_cpha_i),
    .wide_i      (cfg_wide_i),
    .load_word_i (load_word),
    .load_o      (load),
    .word_done_o (done),
    .rx_word_o   (rx_word),
    .miso_o
  );

  assign dma_req_o  = (cnt_q != '0) && ((dir == DIR_TX) ? !full : !empty);
  assign acc        = dma_ack_i && dma_req_o;
  assign push       = (dir == DIR_TX) ? acc : (done && !full);
  assign pop        = (dir == DIR_TX) ? (load && !empty) : acc;
  assign fifo_wdata = (dir == DIR_TX) ? dma_wdata_i : rx_word;

  spi_dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (cnt_load_i),
    .push_i  (push),
    .wdata_i (fifo_wdata),
    .pop_i   (pop),
    .head_o  (head),
    .full_o  (full),
    .empty_o (empty)
  );

  always_comb begin
    if (dir == DIR_TX)
      load_word = !empty ? head : (cfg_zero_fill_i ? '0 : last_q);
    else
      load_word = cfg_zero_fill_i ? '0 : tdbr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      tdbr_q     <= '0;
      last_q     <= '0;
      rx_buf_o   <= '0;
      underrun_o <= 1'b0;
    end else begin
      if (cnt_load_i) cnt_q <= cnt_value_i;
      else if (acc)   cnt_q <= cnt_q - CW'(1);
      if (tx_wr_i) tdbr_q <= tx_wdata_i;
      if (dir == DIR_TX && load && !empty) last_q <= head;
      if (dir == DIR_RX && done && (!full || cfg_overwrite_i)) rx_buf_o <= rx_word;
      underrun_o <= (dir == DIR_TX) && load && empty;
    end
  end

  assign cnt_o       = cnt_q;
  assign dma_rdata_o = head;
  assign tx_empty_o  = (dir == DIR_TX) ? empty : 1'b1;

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_i && dma_req_o && !cnt_load_i) |=> (cnt_o == $past(cnt_o) - CW'(1)));
  // R4
  cnt_zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0) |-> !dma_req_o);
  // R8
  rx_no_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir == DIR_RX) |-> (tx_empty_o && !underrun_o));
  // R10
  tx_rx_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir == DIR_TX) |=> $stable(rx_buf_o));
  // R6
  drop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir == DIR_RX && done && full && !cfg_overwrite_i) |=> $stable(rx_buf_o));
endmodule

// File: tb/spi_dma_slave_tb_top.sv
module spi_dma_slave_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_tx_dir_i = 0, cfg_wide_i = 0, cfg_cpol_i = 0, cfg_cpha_i = 0;
  logic        cfg_overwrite_i = 0, cfg_zero_fill_i = 1;
  logic        sck_i = 0, mosi_i = 0, ss_ni = 1, miso_o;
  logic        dma_req_o, dma_ack_i = 0;
  logic [15:0] dma_wdata_i = '0, dma_rdata_o;
  logic        cnt_load_i = 0;
  logic [15:0] cnt_value_i = '0, cnt_o;
  logic        tx_wr_i = 0;
  logic [15:0] tx_wdata_i = '0, rx_buf_o;
  logic        tx_empty_o, underrun_o;

  int n_chk = 0, n_bad = 0, n_under = 0;
  bit done_flag = 0;

  always #5 clk_i = ~clk_i;

  spi_dma_slave dut_i (.*);

  always @(posedge clk_i) if (underrun_o) n_under++;

  task automatic wc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fit(input logic [15:0] w, input logic wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic set_mode(input logic pol, input logic pha, input logic wide);
    cfg_cpol_i = pol; cfg_cpha_i = pha; cfg_wide_i = wide;
    sck_i = pol;
    wc(8);
  endtask

  task automatic ss_begin();
    ss_ni = 0; wc(8);
  endtask

  task automatic ss_end();
    wc(8); ss_ni = 1; wc(8);
  endtask

  task automatic xfer(input logic [15:0] mo, output logic [15:0] mi);
    int n;
    n = cfg_wide_i ? 16 : 8;
    mi = '0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!cfg_cpha_i) begin
        mosi_i = mo[i]; wc(6); mi[i] = miso_o;
        sck_i = ~cfg_cpol_i; wc(8); sck_i = cfg_cpol_i; wc(2);
      end else begin
        sck_i = ~cfg_cpol_i; wc(8); mosi_i = mo[i]; wc(4); mi[i] = miso_o;
        sck_i = cfg_cpol_i; wc(4);
      end
    end
  endtask

  task automatic load_cnt(input logic [15:0] v);
    cnt_value_i = v; cnt_load_i = 1; wc(1); cnt_load_i = 0; wc(1);
  endtask

  task automatic dma_pop(output logic [15:0] d);
    d = dma_rdata_o; dma_ack_i = 1; wc(1); dma_ack_i = 0; wc(1);
  endtask

  task automatic dma_push(input logic [15:0] d);
    dma_wdata_i = d; dma_ack_i = 1; wc(1); dma_ack_i = 0; wc(1);
  endtask

  initial begin
    logic [15:0] w [8];
    logic [15:0] mi, rd, keep, tdbr;
    int seed;
    seed = $urandom(32'h5eed_0618);
    wc(3); rst_ni = 1; wc(4);

    // reset state
    chk("R1 reset req", dma_req_o, 0);
    chk("R8 reset txe", tx_empty_o, 1);
    chk("R3 reset cnt", cnt_o, 0);
    chk("R4 reset rxbuf", rx_buf_o, 0);

    // receive, mode 0, 8-bit, zero fill
    set_mode(0, 0, 0);
    load_cnt(3);
    ss_begin();
    for (int k = 0; k < 3; k++) begin
      w[k] = 16'($urandom);
      xfer(w[k], mi);
      chk("R7 zero fill miso", mi, 0);
    end
    ss_end();
    chk("R11 rxbuf byte", rx_buf_o, fit(w[2], 0));
    chk("R1 req with data", dma_req_o, 1);
    for (int k = 0; k < 3; k++) begin
      dma_pop(rd);
      chk("R12 drain order", rd, fit(w[k], 0));
    end
    chk("R3 cnt after drain", cnt_o, 0);
    chk("R1 req after drain", dma_req_o, 0);
    dma_push(16'h1234);
    chk("R3 ack without req", cnt_o, 0);

    // count zero, serial keeps going; mode 3, 16-bit, repeat TDBR
    tdbr = 16'($urandom);
    tx_wdata_i = tdbr; tx_wr_i = 1; wc(1); tx_wr_i = 0;
    cfg_zero_fill_i = 0;
    set_mode(1, 1, 1);
    ss_begin();
    for (int k = 0; k < 2; k++) begin
      w[k] = 16'($urandom);
      xfer(w[k], mi);
      chk("R7 repeat tdbr", mi, tdbr);
    end
    ss_end();
    chk("R4 rxbuf at cnt 0", rx_buf_o, w[1]);
    chk("R4 no req at cnt 0", dma_req_o, 0);
    chk("R8 txe in rx", tx_empty_o, 1);

    // full FIFO, drop policy; mode 1, 8-bit
    cfg_overwrite_i = 0;
    set_mode(0, 1, 0);
    load_cnt(8);
    ss_begin();
    for (int k = 0; k < 5; k++) begin w[k] = 16'($urandom); xfer(w[k], mi); end
    ss_end();
    chk("R6 drop keeps rxbuf", rx_buf_o, fit(w[3], 0));
    for (int k = 0; k < 4; k++) begin
      dma_pop(rd);
      chk("R6 fifo kept", rd, fit(w[k], 0));
    end
    chk("R1 empty no req", dma_req_o, 0);

    // full FIFO, overwrite policy; mode 2, 16-bit
    cfg_overwrite_i = 1;
    set_mode(1, 0, 1);
    load_cnt(8);
    ss_begin();
    for (int k = 0; k < 6; k++) begin w[k] = 16'($urandom); xfer(w[k], mi); end
    ss_end();
    chk("R5 overwrite rxbuf", rx_buf_o, w[5]);
    for (int k = 0; k < 4; k++) begin
      dma_pop(rd);
      chk("R5 fifo kept", rd, w[k]);
    end
    chk("R8 no underrun in rx", n_under, 0);

    // random receive rounds
    for (int r = 0; r < 6; r++) begin
      int n;
      logic [2:0] m;
      m = 3'($urandom);
      n = 1 + ($urandom % 4);
      set_mode(m[0], m[1], m[2]);
      load_cnt(16'(n));
      ss_begin();
      for (int k = 0; k < n; k++) begin w[k] = 16'($urandom); xfer(w[k], mi); end
      ss_end();
      chk("R11 random rxbuf", rx_buf_o, fit(w[n-1], m[2]));
      for (int k = 0; k < n; k++) begin
        dma_pop(rd);
        chk("R12 random order", rd, fit(w[k], m[2]));
      end
      chk("R3 random cnt", cnt_o, 0);
    end

    // transmit, mode 0, 16-bit, repeat last
    cfg_tx_dir_i = 1; cfg_zero_fill_i = 0;
    set_mode(0, 0, 1);
    keep = rx_buf_o;
    load_cnt(6);
    chk("R2 req when empty", dma_req_o, 1);
    chk("R2 txe when empty", tx_empty_o, 1);
    for (int k = 0; k < 4; k++) begin w[k] = 16'($urandom); dma_push(w[k]); end
    chk("R2 no req when full", dma_req_o, 0);
    chk("R2 txe when filled", tx_empty_o, 0);
    chk("R3 cnt after fill", cnt_o, 2);
    n_under = 0;
    ss_begin();
    for (int k = 0; k < 6; k++) begin
      xfer(16'($urandom), mi);
      chk("R9 tx word", mi, w[k < 4 ? k : 3]);
    end
    ss_end();
    chk("R9 underrun count", n_under, 3);
    chk("R10 rxbuf ignored", rx_buf_o, keep);
    chk("R10 no serial push", tx_empty_o, 1);
    chk("R2 req with room", dma_req_o, 1);
    cfg_zero_fill_i = 1;
    ss_begin();
    xfer(16'hffff, mi);
    ss_end();
    chk("R9 zero fill tx", mi, 0);

    // transmit, mode 3, 8-bit
    cfg_zero_fill_i = 0;
    set_mode(1, 1, 0);
    for (int k = 0; k < 2; k++) begin w[k] = 16'($urandom); dma_push(w[k]); end
    chk("R3 cnt exhausted", cnt_o, 0);
    chk("R2 no req at cnt 0", dma_req_o, 0);
    ss_begin();
    for (int k = 0; k < 3; k++) begin
      xfer(16'($urandom), mi);
      chk("R11 tx byte", mi, fit(w[k < 2 ? k : 1], 0));
    end
    ss_end();
    chk("R10 rxbuf ignored 8b", rx_buf_o, keep);

    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule